// File: doc/BRIEF.md
# Atomic Halfword Bit-Clear Unit

This unit executes one kind of atomic memory operation for a processor core: it reads a 16-bit halfword, clears in it every bit that is set in an operand, writes the result back to the same address, and returns the value it read. A core issues a 32-bit load-store instruction word together with a one-cycle `start` pulse. The unit shows the register indices it needs as combinational outputs and samples the register values, the stack pointer, a feature-enable strap and the privilege level in that same cycle.

If the word belongs to the halfword bit-clear class, the feature is enabled and the address passes its check, the unit holds a bus lock. It issues a read, waits for the acknowledge, and then issues the write. The lock drops with the write acknowledge. The read value is zero-extended and handed to the register writeback port. Every outcome ends with a one-cycle `done` pulse. On that pulse at most one of three status flags is set: not this class, feature disabled, or stack-pointer misalignment.

Two bits of the word select memory ordering qualifiers. The acquire qualifier is dropped when the destination register is the zero register. The length of a sequence depends only on the memory acknowledge timing and never on data values.

Top module: `hclr_atomic_unit`

## Requirements
- R1: A word is accepted only when `(insn & 32'hFF20_FC00) == 32'h7820_1000`. Any other word ends with `done` and `nomatch` two cycles after the start cycle, and makes no memory request.
- R2: An accepted word sampled while `feat_en` is 0 ends with `done` and `undef`, and makes no memory request.
- R3: An executed operation reads one halfword and then writes `old & ~operand` to the same address. The operand is `rs_val[15:0]`.
- R4: On `done`, `wb_en` is 1 exactly when insn[4:0] (destination) is not 31. Then `wb_idx` is that index and `wb_data` is the read value zero-extended to 32 bits.
- R5: `rs_idx` equals insn[20:16] and `rn_idx` equals insn[9:5].
- R6: When insn[9:5] is not 31, the address is `rn_val`. When it is 31, the address is `sp_val`. If any of `sp_val[3:0]` is nonzero, the operation ends with `done` and `align_fault` and makes no memory request.
- R7: During the requests, `mem_acq` equals insn[23] AND (destination not 31), and `mem_rel` equals insn[22].
- R8: `mem_lock` is high from the first cycle of the read request until the write acknowledge, without a gap, and is low in the cycle after that acknowledge.
- R9: The write request is made only after the read acknowledge. A request holds its address and direction until it is acknowledged.
- R10: During the requests, `mem_tagchk` is 1 exactly when insn[9:5] is not 31, and `mem_priv` equals `lvl_above_user` sampled at start.
- R11: With a memory that acknowledges after L waiting cycles per request, `done` appears 4+2L cycles after the start cycle for any data values.
- R12: Reset gives idle: no request, no lock, no `done`, no `busy`, no writeback. Reset during a locked sequence drops the request and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue pulse, taken when idle |
| insn | input | 32 | Instruction word |
| feat_en | input | 1 | Atomic operations enabled strap |
| lvl_above_user | input | 1 | Current privilege above the lowest level |
| rs_idx | output | 5 | Operand register index |
| rn_idx | output | 5 | Base register index |
| rs_val | input | REG_W (64) | Operand register value |
| rn_val | input | ADDR_W (64) | Base register value |
| sp_val | input | ADDR_W (64) | Stack pointer value |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W (64) | Request address |
| mem_wdata | output | DATA_W (16) | Write data |
| mem_lock | output | 1 | Bus lock over the read-modify-write |
| mem_acq | output | 1 | Acquire ordering qualifier |
| mem_rel | output | 1 | Release ordering qualifier |
| mem_tagchk | output | 1 | Tag check requested |
| mem_priv | output | 1 | Privileged access |
| mem_ack | input | 1 | Request acknowledge |
| mem_rdata | input | DATA_W (16) | Read data, valid with the read acknowledge |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |
| nomatch | output | 1 | Word not of this class, with done |
| undef | output | 1 | Feature disabled, with done |
| align_fault | output | 1 | Stack pointer misaligned, with done |
| wb_en | output | 1 | Register writeback enable |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | WB_W (32) | Writeback value |

## Verification
The bench builds the unit with its default parameters: 64-bit address and register width, a 16-bit halfword, a 32-bit writeback and four alignment bits. With these values the stack-pointer alignment boundary and the upper half of the writeback word can be observed directly. The vector table covers all four ordering combinations, with destination and base set to 31 and to other registers. The bench's memory latency is a run-time variable, so the same build also exercises a lock held over waiting cycles and the 4+2L completion time.

// File: rtl/hclr_pkg.sv
// Package: shared constants and types for the atomic halfword bit-clear unit.
// Assumes a 32-bit instruction word with 5-bit register indices.
package hclr_pkg;

    localparam int IDX_W = 5;
    localparam logic [IDX_W-1:0] ZERO_REG = 5'd31;

    // Fixed-bit pattern of the halfword bit-clear class
    localparam logic [31:0] CLASS_MASK = 32'hFF20_FC00;
    localparam logic [31:0] CLASS_BITS = 32'h7820_1000;

    // Field positions decoded by this unit
    localparam int ACQ_BIT = 23;
    localparam int REL_BIT = 22;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_RD    = 3'd2,
        ST_WR    = 3'd3,
        ST_END   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic             match;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] base;
        logic [IDX_W-1:0] dst;
        logic             acq;
        logic             rel;
        logic             tagchk;
    } dec_t;

endpackage

// File: rtl/hclr_decode.sv
// Module: combinational decoder for the halfword bit-clear instruction word.
// Assumes nothing about timing; outputs follow the word directly.
module hclr_decode
    import hclr_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);

    // Extract fields and derive ordering and tag-check qualifiers
    always_comb begin
        dec.match  = (insn & CLASS_MASK) == CLASS_BITS;
        dec.src    = insn[20:16];
        dec.base   = insn[9:5];
        dec.dst    = insn[4:0];
        dec.acq    = insn[ACQ_BIT] && (insn[4:0] != ZERO_REG);
        dec.rel    = insn[REL_BIT];
        dec.tagchk = insn[9:5] != ZERO_REG;
    end

endmodule

// File: rtl/hclr_addr_sel.sv
// Module: picks the base address (register or stack pointer) and flags
// stack-pointer misalignment. Assumes ALIGN_BITS is at least 1.
module hclr_addr_sel
    import hclr_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int ALIGN_BITS = 4
) (
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] sp_val,
    output logic [ADDR_W-1:0] addr,
    output logic              misaligned
);

    localparam int LOW_W = ALIGN_BITS;

    logic use_sp;

    // Select the address source and test the stack-pointer low bits
    always_comb begin
        use_sp     = base_idx == ZERO_REG;
        addr       = use_sp ? sp_val : reg_val;
        misaligned = use_sp && (sp_val[LOW_W-1:0] != '0);
    end

endmodule

// File: rtl/hclr_seq.sv
// Module: sequencer for the locked read-modify-write. Samples all operands
// at start, checks class, feature and alignment, then reads, writes and
// reports. Assumes the memory holds read data valid with its acknowledge.
module hclr_seq
    import hclr_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 16,
    parameter int WB_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  dec_t              dec_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              misaligned_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              feat_en,
    input  logic              priv_in,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_lock,
    output logic              mem_acq,
    output logic              mem_rel,
    output logic              mem_tagchk,
    output logic              mem_priv,
    output logic              done,
    output logic              busy,
    output logic              nomatch,
    output logic              undef,
    output logic              align_fault,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [WB_W-1:0]   wb_data
);

    localparam int PAD_W = WB_W - DATA_W;

    seq_state_e        state_q;
    dec_t              dec_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] old_q;
    logic              mis_q;
    logic              feat_q;
    logic              priv_q;
    logic              lock_q;
    logic              nomatch_q;
    logic              undef_q;
    logic              fault_q;
    logic              in_req;
    logic              ok;

    // Advance the sequence and hold the bus lock and outcome flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lock_q    <= 1'b0;
            nomatch_q <= 1'b0;
            undef_q   <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    nomatch_q <= !dec_q.match;
                    undef_q   <= dec_q.match && !feat_q;
                    fault_q   <= dec_q.match && feat_q && mis_q;
                    if (dec_q.match && feat_q && !mis_q) begin
                        lock_q  <= 1'b1;
                        state_q <= ST_RD;
                    end else begin
                        state_q <= ST_END;
                    end
                end
                ST_RD: begin
                    if (mem_ack) begin
                        state_q <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_ack) begin
                        lock_q  <= 1'b0;
                        state_q <= ST_END;
                    end
                end
                ST_END: begin
                    nomatch_q <= 1'b0;
                    undef_q   <= 1'b0;
                    fault_q   <= 1'b0;
                    state_q   <= ST_IDLE;
                end
                default: begin
                    lock_q  <= 1'b0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Capture the decoded word and operands at start, and the read value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= '0;
            addr_q <= '0;
            opnd_q <= '0;
            old_q  <= '0;
            mis_q  <= 1'b0;
            feat_q <= 1'b0;
            priv_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                dec_q  <= dec_in;
                addr_q <= addr_in;
                opnd_q <= opnd_in;
                mis_q  <= misaligned_in;
                feat_q <= feat_en;
                priv_q <= priv_in;
            end
            if (state_q == ST_RD && mem_ack) begin
                old_q <= mem_rdata;
            end
        end
    end

    // Drive the memory channel, the writeback port and the status outputs
    always_comb begin
        in_req      = (state_q == ST_RD) || (state_q == ST_WR);
        ok          = !nomatch_q && !undef_q && !fault_q;
        mem_req     = in_req;
        mem_we      = state_q == ST_WR;
        mem_addr    = addr_q;
        mem_wdata   = old_q & ~opnd_q;
        mem_lock    = lock_q;
        mem_acq     = in_req && dec_q.acq;
        mem_rel     = in_req && dec_q.rel;
        mem_tagchk  = in_req && dec_q.tagchk;
        mem_priv    = in_req && priv_q;
        done        = state_q == ST_END;
        busy        = state_q != ST_IDLE;
        nomatch     = done && nomatch_q;
        undef       = done && undef_q;
        align_fault = done && fault_q;
        wb_en       = done && ok && (dec_q.dst != ZERO_REG);
        wb_idx      = dec_q.dst;
        wb_data     = {{PAD_W{1'b0}}, old_q};
    end

endmodule

// File: rtl/hclr_atomic_unit.sv
// Module: top of the atomic halfword bit-clear unit. Decodes the live word
// for register indices, selects the address and runs the sequencer.
// Assumes register values are valid in the cycle start is high.
module hclr_atomic_unit
    import hclr_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int REG_W      = 64,
    parameter int DATA_W     = 16,
    parameter int WB_W       = 32,
    parameter int ALIGN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       insn,
    input  logic              feat_en,
    input  logic              lvl_above_user,
    output logic [4:0]        rs_idx,
    output logic [4:0]        rn_idx,
    input  logic [REG_W-1:0]  rs_val,
    input  logic [ADDR_W-1:0] rn_val,
    input  logic [ADDR_W-1:0] sp_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_lock,
    output logic              mem_acq,
    output logic              mem_rel,
    output logic              mem_tagchk,
    output logic              mem_priv,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              busy,
    output logic              nomatch,
    output logic              undef,
    output logic              align_fault,
    output logic              wb_en,
    output logic [4:0]        wb_idx,
    output logic [WB_W-1:0]   wb_data
);

    dec_t              dec_w;
    logic [ADDR_W-1:0] addr_w;
    logic              mis_w;

    hclr_decode u_dec (
        .insn (insn),
        .dec  (dec_w)
    );

    // Register indices go straight out for the register-file read
    assign rs_idx = dec_w.src;
    assign rn_idx = dec_w.base;

    hclr_addr_sel #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_addr (
        .base_idx   (dec_w.base),
        .reg_val    (rn_val),
        .sp_val     (sp_val),
        .addr       (addr_w),
        .misaligned (mis_w)
    );

    hclr_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WB_W   (WB_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .dec_in        (dec_w),
        .addr_in       (addr_w),
        .misaligned_in (mis_w),
        .opnd_in       (rs_val[DATA_W-1:0]),
        .feat_en       (feat_en),
        .priv_in       (lvl_above_user),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_lock      (mem_lock),
        .mem_acq       (mem_acq),
        .mem_rel       (mem_rel),
        .mem_tagchk    (mem_tagchk),
        .mem_priv      (mem_priv),
        .done          (done),
        .busy          (busy),
        .nomatch       (nomatch),
        .undef         (undef),
        .align_fault   (align_fault),
        .wb_en         (wb_en),
        .wb_idx        (wb_idx),
        .wb_data       (wb_data)
    );

endmodule

// File: rtl/hclr_atomic_chk.sv
// Module: protocol checker for the atomic halfword bit-clear unit, bound to
// the top. Assumes the parameters match the bound instance.
module hclr_atomic_chk #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 16,
    parameter int WB_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_lock,
    input logic              mem_acq,
    input logic              mem_ack,
    input logic              done,
    input logic              nomatch,
    input logic              undef,
    input logic              align_fault,
    input logic              wb_en,
    input logic [4:0]        wb_idx,
    input logic [WB_W-1:0]   wb_data
);

    // R12
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !mem_lock && !done && !busy && !wb_en));

    // R8
    lock_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    // R8
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (!mem_lock && done));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && $stable(mem_addr)));

    // R9
    wr_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_req && mem_ack));

    // R7
    acq_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_acq |-> (mem_req && wb_idx != 5'd31));

    // R2
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nomatch || undef || align_fault) |-> (done && !wb_en && !mem_lock && !mem_req));

    // R1
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nomatch, undef, align_fault}));

    // R4
    wb_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && wb_idx != 5'd31 && wb_data[WB_W-1:DATA_W] == '0));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

bind hclr_atomic_unit hclr_atomic_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WB_W   (WB_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_lock    (mem_lock),
    .mem_acq     (mem_acq),
    .mem_ack     (mem_ack),
    .done        (done),
    .nomatch     (nomatch),
    .undef       (undef),
    .align_fault (align_fault),
    .wb_en       (wb_en),
    .wb_idx      (wb_idx),
    .wb_data     (wb_data)
);

// File: tb/hclr_atomic_unit_tb.sv
// Bench: vector table over ordering and register variants, then directed
// tests for class rejection, feature off, alignment, latency and reset.
module hclr_atomic_unit_tb_top;

    localparam logic [31:0] MASK = 32'hFF20_FC00;
    localparam logic [31:0] BASEW = 32'h7820_1000;

    typedef struct packed {
        logic        a;
        logic        r;
        logic [4:0]  rs;
        logic [4:0]  rn;
        logic [4:0]  rt;
        logic [15:0] opnd;
        logic [15:0] mval;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 5'd3,  5'd5,  5'd7,  16'hF0F0, 16'h1234},
        '{1'b1, 1'b0, 5'd4,  5'd31, 5'd8,  16'h00FF, 16'hABCD},
        '{1'b0, 1'b1, 5'd6,  5'd9,  5'd31, 16'hFFFF, 16'h5A5A},
        '{1'b1, 1'b1, 5'd10, 5'd31, 5'd31, 16'h0000, 16'hC3C3},
        '{1'b1, 1'b0, 5'd11, 5'd12, 5'd31, 16'h8001, 16'hFFFF},
        '{1'b1, 1'b1, 5'd2,  5'd13, 5'd14, 16'h1111, 16'h7777},
        '{1'b0, 1'b1, 5'd15, 5'd31, 5'd1,  16'hAAAA, 16'hFFFF},
        '{1'b0, 1'b0, 5'd16, 5'd17, 5'd31, 16'h0F0F, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = 32'h0;
    logic        feat_en = 1'b1;
    logic        lvl = 1'b0;
    logic [4:0]  rs_idx, rn_idx;
    logic [63:0] rs_val, rn_val;
    logic [63:0] sp_val = 64'h40;
    logic        mem_req, mem_we, mem_lock, mem_acq, mem_rel, mem_tagchk, mem_priv;
    logic [63:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'h0;
    logic        done, busy, nomatch, undef, align_fault, wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;

    logic [63:0] regs [32];
    logic [15:0] mem_model [512];

    int errors = 0;
    int checks = 0;
    int mem_lat = 0;
    int lat_cnt = 0;
    int cyc = 0;

    // per-operation observations
    int          n_rd, n_wr, n_req_cyc, lock_gap;
    logic        s_acq, s_rel, s_tag, s_priv;
    logic [63:0] rd_addr, wr_addr;
    logic        s_done, s_wb_en, s_nomatch, s_undef, s_fault;
    logic [31:0] s_wb_data;
    logic [4:0]  s_wb_idx;
    int          op_cycles;

    always #5 clk = ~clk;

    assign rs_val = regs[rs_idx];
    assign rn_val = regs[rn_idx];

    hclr_atomic_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .insn           (insn),
        .feat_en        (feat_en),
        .lvl_above_user (lvl),
        .rs_idx         (rs_idx),
        .rn_idx         (rn_idx),
        .rs_val         (rs_val),
        .rn_val         (rn_val),
        .sp_val         (sp_val),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_lock       (mem_lock),
        .mem_acq        (mem_acq),
        .mem_rel        (mem_rel),
        .mem_tagchk     (mem_tagchk),
        .mem_priv       (mem_priv),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .done           (done),
        .busy           (busy),
        .nomatch        (nomatch),
        .undef          (undef),
        .align_fault    (align_fault),
        .wb_en          (wb_en),
        .wb_idx         (wb_idx),
        .wb_data        (wb_data)
    );

    // Behavioural memory with programmable latency, plus request monitor
    always @(negedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && rst_n) begin
            n_req_cyc = n_req_cyc + 1;
            if (!mem_lock) lock_gap = lock_gap + 1;
            s_acq  = s_acq | mem_acq;
            s_rel  = s_rel | mem_rel;
            s_tag  = mem_tagchk;
            s_priv = mem_priv;
            if (lat_cnt >= mem_lat) begin
                lat_cnt = 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem_model[mem_addr[9:1]] = mem_wdata;
                    wr_addr = mem_addr;
                    n_wr = n_wr + 1;
                end else begin
                    mem_rdata <= mem_model[mem_addr[9:1]];
                    rd_addr = mem_addr;
                    n_rd = n_rd + 1;
                end
            end else begin
                lat_cnt = lat_cnt + 1;
            end
        end else begin
            lat_cnt = 0;
        end
    end

    // Watchdog: a hung run counts as a failed check and still reports
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL R11 watchdog expired: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic a, input logic r, input logic [4:0] rs,
                                       input logic [4:0] rn, input logic [4:0] rt);
        return BASEW | (32'(a) << 23) | (32'(r) << 22) | (32'(rs) << 16)
                     | (32'(rn) << 5) | 32'(rt);
    endfunction

    // Issue one word and wait for done, recording what was seen
    task automatic run_op(input logic [31:0] w);
        n_rd = 0; n_wr = 0; n_req_cyc = 0; lock_gap = 0;
        s_acq = 1'b0; s_rel = 1'b0; s_tag = 1'b0; s_priv = 1'b0;
        @(negedge clk);
        insn  = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_cycles = 1;
        while (!done && op_cycles < 200) begin
            @(negedge clk);
            op_cycles = op_cycles + 1;
        end
        s_done    = done;
        s_wb_en   = wb_en;
        s_wb_idx  = wb_idx;
        s_wb_data = wb_data;
        s_nomatch = nomatch;
        s_undef   = undef;
        s_fault   = align_fault;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 64'h0;
        for (int i = 0; i < 512; i++) mem_model[i] = 16'h0;

        // R12: reset state
        repeat (3) @(negedge clk);
        chk(!mem_req && !mem_lock && !done && !busy && !wb_en, "R12 reset idle",
            {mem_req, mem_lock, done, busy, wb_en}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6 R7 R10 R11: vector table
        for (int v = 0; v < NV; v++) begin
            logic [63:0] addr;
            logic [15:0] expw;
            regs[VECS[v].rs] = {48'hDEAD_BEEF_0000, VECS[v].opnd};
            if (VECS[v].rn == 5'd31) begin
                addr = 64'h40 + 64'(v * 16);
                sp_val = addr;
            end else begin
                addr = 64'h100 + 64'(v * 2);
                regs[VECS[v].rn] = addr;
            end
            mem_model[addr[9:1]] = VECS[v].mval;
            expw = VECS[v].mval & ~VECS[v].opnd;
            lvl = v[0];
            run_op(mk(VECS[v].a, VECS[v].r, VECS[v].rs, VECS[v].rn, VECS[v].rt));
            chk(n_rd == 1 && n_wr == 1, "R3 one read one write", 64'(n_rd * 16 + n_wr), 64'h11);
            chk(mem_model[addr[9:1]] == expw, "R3 cleared value", 64'(mem_model[addr[9:1]]), 64'(expw));
            chk(rd_addr == addr && wr_addr == addr, "R6 address", rd_addr, addr);
            chk(rs_idx == VECS[v].rs && rn_idx == VECS[v].rn, "R5 register indices",
                {rs_idx, rn_idx}, {VECS[v].rs, VECS[v].rn});
            chk(s_wb_en == (VECS[v].rt != 5'd31), "R4 writeback enable", 64'(s_wb_en),
                64'(VECS[v].rt != 5'd31));
            if (VECS[v].rt != 5'd31)
                chk(s_wb_data == {16'h0, VECS[v].mval} && s_wb_idx == VECS[v].rt,
                    "R4 writeback data", 64'(s_wb_data), 64'(VECS[v].mval));
            chk(s_acq == (VECS[v].a && VECS[v].rt != 5'd31), "R7 acquire", 64'(s_acq),
                64'(VECS[v].a && VECS[v].rt != 5'd31));
            chk(s_rel == VECS[v].r, "R7 release", 64'(s_rel), 64'(VECS[v].r));
            chk(s_tag == (VECS[v].rn != 5'd31) && s_priv == v[0], "R10 tag and privilege",
                {s_tag, s_priv}, {(VECS[v].rn != 5'd31), v[0]});
            chk(lock_gap == 0, "R8 lock over requests", 64'(lock_gap), 64'h0);
            chk(op_cycles == 4, "R11 cycles at zero latency", 64'(op_cycles), 64'd4);
        end

        // R1: flipping any fixed class bit rejects the word
        for (int b = 0; b < 32; b++) begin
            if (MASK[b]) begin
                regs[3] = 64'h0; regs[5] = 64'h100;
                run_op(mk(1'b0, 1'b0, 5'd3, 5'd5, 5'd7) ^ (32'h1 << b));
                chk(s_done && s_nomatch && n_req_cyc == 0 && op_cycles == 2 && !s_wb_en,
                    "R1 class mismatch", {s_nomatch, 32'(n_req_cyc), 32'(op_cycles)},
                    {1'b1, 32'd0, 32'd2});
            end
        end

        // R2: feature disabled
        feat_en = 1'b0;
        regs[5] = 64'h120;
        mem_model[9'h90] = 16'hBEEF;
        run_op(mk(1'b1, 1'b1, 5'd3, 5'd5, 5'd7));
        chk(s_undef && !s_nomatch && n_req_cyc == 0 && !s_wb_en && mem_model[9'h90] == 16'hBEEF,
            "R2 feature off", {s_undef, 32'(n_req_cyc)}, {1'b1, 32'd0});
        feat_en = 1'b1;

        // R6: misaligned stack pointer faults, aligned one with register base is unaffected
        sp_val = 64'h48;
        run_op(mk(1'b0, 1'b0, 5'd3, 5'd31, 5'd7));
        chk(s_fault && n_req_cyc == 0 && !s_wb_en, "R6 sp alignment fault",
            {s_fault, 32'(n_req_cyc)}, {1'b1, 32'd0});
        regs[5] = 64'h12;
        mem_model[9'h09] = 16'h00F0;
        regs[3] = 64'h0010;
        run_op(mk(1'b0, 1'b0, 5'd3, 5'd5, 5'd7));
        chk(!s_fault && mem_model[9'h09] == 16'h00E0, "R6 register base ignores sp bits",
            64'(mem_model[9'h09]), 64'h00E0);
        sp_val = 64'h40;

        // R8 R9 R11: latency 2, two data sets give the same completion time
        mem_lat = 2;
        regs[5] = 64'h140; mem_model[9'hA0] = 16'hFFFF; regs[3] = 64'h0000;
        run_op(mk(1'b1, 1'b1, 5'd3, 5'd5, 5'd7));
        chk(op_cycles == 8 && lock_gap == 0 && mem_model[9'hA0] == 16'hFFFF,
            "R11 latency 2 data A", 64'(op_cycles), 64'd8);
        regs[5] = 64'h142; mem_model[9'hA1] = 16'h0000; regs[3] = 64'hFFFF;
        run_op(mk(1'b1, 1'b1, 5'd3, 5'd5, 5'd7));
        chk(op_cycles == 8 && n_req_cyc == 6 && lock_gap == 0,
            "R9 latency 2 data B request hold", {32'(op_cycles), 32'(n_req_cyc)}, {32'd8, 32'd6});
        chk(s_wb_data == 32'h0 && s_wb_en, "R4 zero read value", 64'(s_wb_data), 64'h0);

        // R12: reset in the middle of a locked sequence
        mem_lat = 20;
        regs[5] = 64'h160;
        @(negedge clk);
        insn = mk(1'b0, 1'b0, 5'd3, 5'd5, 5'd7);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_req && mem_lock, "R8 lock held while waiting", {mem_req, mem_lock}, 2'b11);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!mem_req && !mem_lock && !busy && !done, "R12 reset mid sequence",
            {mem_req, mem_lock, busy, done}, 4'h0);
        rst_n = 1'b1;
        mem_lat = 0;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule